// File: doc/BRIEF.md
# Interlaced Field Scan-Out Sequencer

This block sits in front of a display timing engine and a pixel DMA address generator that only know progressive scan. It turns them into an interlaced source by running them one field at a time. From the full-frame vertical mode values it works out the per-field visible, sync, back-porch and front-porch counts. It presents them in the minus-one form the timing engine expects.

While an interlaced mode runs, the timing engine raises a line-match strobe once per field, partway down the field. On each strobe the sequencer flips between the upper and lower field. It lengthens the front porch by one line for the lower field and shortens it again for the upper one. It also re-issues the next field's start address. The lower field starts one buffer line further into the frame buffer, and the DMA stride is doubled so that each field reads every other line.

Software submits buffers through a base/stride port. A stop request disarms scan-out and forgets the recorded buffer, and the block reports idle once the pixel FIFO has drained. In progressive mode the block passes the frame timing through and ignores the line-match strobe.

Top module: `ilace_field_seq`

## Requirements
- R1: In interlaced mode, with field_vis = vdisp>>1 and field_tot = vtotal>>1, the block drives vis_m1 = field_vis-1 and sync_m1 = field_tot-2.
- R2: In interlaced mode the base front porch fp0 is (vsstart-vdisp-2)>>1 when vsstart >= vdisp+4, and 1 otherwise. In the upper field (lower_field=0), fp_m1 = fp0-1.
- R3: In interlaced mode the back porch is bp = max(0, field_tot-field_vis-fp0). bp_m1 = bp-1, and bp_en is 1 only when bp is nonzero. fp_en and sync_en are always 1.
- R4: In progressive mode vis_m1 = vdisp-1, sync_m1 = vsend-vsstart-1, bp_m1 = vtotal-vsstart-1 (the back porch includes the sync width) and fp_m1 = vsstart-vdisp-1. Each enable is 1 exactly when its span is nonzero: bp_en when vtotal!=vsstart, fp_en when vsstart!=vdisp, sync_en when vsend!=vsstart.
- R5: In interlaced mode each line_match pulse toggles lower_field. fp_m1 is always fp0-1+lower_field, so the lower field has one more front-porch line.
- R6: A buffer submission in interlaced mode drives dma_stride = 2*sub_stride and dma_addr = sub_addr + (lower_field ? sub_stride : 0), with a one-cycle dma_wr pulse.
- R7: On line_match in interlaced mode the block re-issues the recorded base, plus the recorded stride when the new field is lower, with a dma_wr pulse. It does this only when the recorded base is nonzero.
- R8: When line_match and sub_valid arrive in the same cycle, the field toggle takes effect first and the submitted address uses the new field.
- R9: cfg_load latches the mode, sets the field to upper, clears the recorded base and arms scan-out (scan_arm=1, idle=0) on the next cycle.
- R10: stop_req drops scan_arm on the next cycle and clears the recorded base. idle rises one cycle after fifo_empty is seen high in the draining state, and not before.
- R11: In progressive mode line_match has no effect: lower_field, fp_m1 and dma_wr are unchanged. Submissions pass through with dma_stride = sub_stride and an unoffset address.
- R12: After reset idle=1, scan_arm=0, lower_field=0, dma_wr=0, dma_addr=0 and dma_stride=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Latch mode and start scan-out |
| cfg_ilace | input | 1 | 1 = interlaced mode |
| cfg_vdisp | input | LW | Full-frame visible lines |
| cfg_vsstart | input | LW | Full-frame sync start line |
| cfg_vsend | input | LW | Full-frame sync end line |
| cfg_vtotal | input | LW | Full-frame total lines |
| sub_valid | input | 1 | Buffer submission strobe |
| sub_addr | input | AW | Buffer base address |
| sub_stride | input | SW | Buffer line stride |
| line_match | input | 1 | Mid-field line-match strobe |
| stop_req | input | 1 | Stop scan-out request |
| fifo_empty | input | 1 | Pixel FIFO empty |
| vis_m1 | output | LW | Visible lines minus one |
| sync_m1 | output | LW | Sync lines minus one |
| bp_m1 | output | LW | Back porch (incl. sync) minus one |
| fp_m1 | output | LW | Front porch minus one |
| bp_en | output | 1 | Back porch enable |
| fp_en | output | 1 | Front porch enable |
| sync_en | output | 1 | Vertical sync enable |
| scan_arm | output | 1 | Arm and auto-repeat for the timing engine |
| idle | output | 1 | Scan-out stopped and drained |
| lower_field | output | 1 | Current field is the lower field |
| dma_wr | output | 1 | Address/stride write strobe |
| dma_addr | output | AW | Field start address |
| dma_stride | output | SW+1 | Programmed DMA stride |

## Verification
The bench targets the front-porch threshold at vsstart = vdisp+4 and a mode whose back porch comes out at zero. A design that got these wrong would pick the wrong base porch or leave the back porch enabled. It checks that the front porch steps by exactly one line between fields and that the lower field's address carries the one-line offset. A design that got these wrong would show a vertically jittering or line-swapped picture. It drives a submission and a line match in the same cycle, where the wrong ordering would place a new buffer in the stale field. It also sends line matches with no buffer recorded, after a stop, and in progressive mode. In those cases a faulty design would issue spurious DMA writes or flip fields when it should not. Finally it holds the FIFO non-empty during the drain, where a faulty design would report idle too early.

// File: rtl/ilace_seq_pkg.sv
package ilace_seq_pkg;
  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_RUN   = 2'd1,
    RS_DRAIN = 2'd2
  } run_state_t;
endpackage

// File: rtl/ilace_field_geom.sv
module ilace_field_geom #(
  parameter int LW = 12
) (
  input  logic          ilace,
  input  logic          lower,
  input  logic [LW-1:0] vdisp,
  input  logic [LW-1:0] vsstart,
  input  logic [LW-1:0] vsend,
  input  logic [LW-1:0] vtotal,
  output logic [LW-1:0] vis_m1,
  output logic [LW-1:0] sync_m1,
  output logic [LW-1:0] bp_m1,
  output logic [LW-1:0] fp_m1,
  output logic          bp_en,
  output logic          fp_en,
  output logic          sync_en
);
  localparam int LX = LW + 1;

  logic [LW-1:0] f_vis, f_tot, f_fp0, f_bp;
  logic [LX-1:0] fp_span, bp_diff;
  logic          wide_fp;

  always_comb begin
    f_vis   = vdisp >> 1;
    f_tot   = vtotal >> 1;
    wide_fp = ({1'b0, vsstart} >= ({1'b0, vdisp} + LX'(4)));
    fp_span = ({1'b0, vsstart} - {1'b0, vdisp} - LX'(2)) >> 1;
    f_fp0   = wide_fp ? fp_span[LW-1:0] : LW'(1);
    bp_diff = {1'b0, f_tot} - {1'b0, f_vis} - {1'b0, f_fp0};
    f_bp    = bp_diff[LW] ? '0 : bp_diff[LW-1:0];
    if (ilace) begin
      vis_m1  = f_vis - LW'(1);
      sync_m1 = f_tot - LW'(2);
      bp_m1   = f_bp - LW'(1);
      fp_m1   = f_fp0 - LW'(1) + LW'(lower);
      bp_en   = |f_bp;
      fp_en   = 1'b1;
      sync_en = 1'b1;
    end else begin
      vis_m1  = vdisp - LW'(1);
      sync_m1 = vsend - vsstart - LW'(1);
      bp_m1   = vtotal - vsstart - LW'(1);
      fp_m1   = vsstart - vdisp - LW'(1);
      bp_en   = (vtotal != vsstart);
      fp_en   = (vsstart != vdisp);
      sync_en = (vsend != vsstart);
    end
  end
endmodule

// File: rtl/ilace_field_flip.sv
module ilace_field_flip #(
  parameter int AW = 32,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ilace,
  input  logic          cfg_load,
  input  logic          stop_req,
  input  logic          line_match,
  input  logic          sub_valid,
  input  logic [AW-1:0] sub_addr,
  input  logic [SW-1:0] sub_stride,
  output logic          lower,
  output logic          rec_valid,
  output logic          dma_wr,
  output logic [AW-1:0] dma_addr,
  output logic [SW:0]   dma_stride
);
  logic          lower_q, lower_d;
  logic [AW-1:0] rec_addr_q, rec_addr_d;
  logic [SW-1:0] rec_strd_q, rec_strd_d;
  logic          wr_q, wr_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [SW:0]   strd_q, strd_d;
  logic          flip;

  always_comb begin
    flip       = line_match & ilace;
    lower_d    = cfg_load ? 1'b0 : (lower_q ^ flip);
    rec_addr_d = rec_addr_q;
    rec_strd_d = rec_strd_q;
    if (sub_valid) begin
      rec_addr_d = sub_addr;
      rec_strd_d = sub_stride;
    end
    if (cfg_load || stop_req) rec_addr_d = '0;
    wr_d   = 1'b0;
    addr_d = addr_q;
    strd_d = strd_q;
    if (!cfg_load) begin
      if (sub_valid) begin
        wr_d   = 1'b1;
        addr_d = sub_addr + ((ilace && lower_d) ? AW'(sub_stride) : '0);
        strd_d = ilace ? {sub_stride, 1'b0} : {1'b0, sub_stride};
      end else if (flip && (rec_addr_q != '0)) begin
        wr_d   = 1'b1;
        addr_d = rec_addr_q + (lower_d ? AW'(rec_strd_q) : '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lower_q    <= 1'b0;
      rec_addr_q <= '0;
      rec_strd_q <= '0;
      wr_q       <= 1'b0;
      addr_q     <= '0;
      strd_q     <= '0;
    end else begin
      lower_q    <= lower_d;
      rec_addr_q <= rec_addr_d;
      rec_strd_q <= rec_strd_d;
      wr_q       <= wr_d;
      addr_q     <= addr_d;
      strd_q     <= strd_d;
    end
  end

  assign lower      = lower_q;
  assign rec_valid  = (rec_addr_q != '0);
  assign dma_wr     = wr_q;
  assign dma_addr   = addr_q;
  assign dma_stride = strd_q;
endmodule

// File: rtl/ilace_run_ctrl.sv
module ilace_run_ctrl
  import ilace_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_load,
  input  logic stop_req,
  input  logic fifo_empty,
  output logic scan_arm,
  output logic idle
);
  run_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (cfg_load) begin
      st_d = RS_RUN;
    end else begin
      case (st_q)
        RS_RUN:   if (stop_req) st_d = RS_DRAIN;
        RS_DRAIN: if (fifo_empty) st_d = RS_IDLE;
        default:  st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= RS_IDLE;
    else        st_q <= st_d;
  end

  assign scan_arm = (st_q == RS_RUN);
  assign idle     = (st_q == RS_IDLE);
endmodule

// File: rtl/ilace_field_seq.sv
module ilace_field_seq #(
  parameter int LW = 12,
  parameter int AW = 32,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic          cfg_ilace,
  input  logic [LW-1:0] cfg_vdisp,
  input  logic [LW-1:0] cfg_vsstart,
  input  logic [LW-1:0] cfg_vsend,
  input  logic [LW-1:0] cfg_vtotal,
  input  logic          sub_valid,
  input  logic [AW-1:0] sub_addr,
  input  logic [SW-1:0] sub_stride,
  input  logic          line_match,
  input  logic          stop_req,
  input  logic          fifo_empty,
  output logic [LW-1:0] vis_m1,
  output logic [LW-1:0] sync_m1,
  output logic [LW-1:0] bp_m1,
  output logic [LW-1:0] fp_m1,
  output logic          bp_en,
  output logic          fp_en,
  output logic          sync_en,
  output logic          scan_arm,
  output logic          idle,
  output logic          lower_field,
  output logic          dma_wr,
  output logic [AW-1:0] dma_addr,
  output logic [SW:0]   dma_stride
);
  logic          ilace_q;
  logic [LW-1:0] vdisp_q, vsstart_q, vsend_q, vtotal_q;
  logic          rec_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ilace_q   <= 1'b0;
      vdisp_q   <= '0;
      vsstart_q <= '0;
      vsend_q   <= '0;
      vtotal_q  <= '0;
    end else if (cfg_load) begin
      ilace_q   <= cfg_ilace;
      vdisp_q   <= cfg_vdisp;
      vsstart_q <= cfg_vsstart;
      vsend_q   <= cfg_vsend;
      vtotal_q  <= cfg_vtotal;
    end
  end

  ilace_field_geom #(.LW(LW)) u_geom (
    .ilace(ilace_q), .lower(lower_field),
    .vdisp(vdisp_q), .vsstart(vsstart_q), .vsend(vsend_q), .vtotal(vtotal_q),
    .vis_m1(vis_m1), .sync_m1(sync_m1), .bp_m1(bp_m1), .fp_m1(fp_m1),
    .bp_en(bp_en), .fp_en(fp_en), .sync_en(sync_en)
  );

  ilace_field_flip #(.AW(AW), .SW(SW)) u_flip (
    .clk(clk), .rst_n(rst_n), .ilace(ilace_q), .cfg_load(cfg_load),
    .stop_req(stop_req), .line_match(line_match), .sub_valid(sub_valid),
    .sub_addr(sub_addr), .sub_stride(sub_stride), .lower(lower_field),
    .rec_valid(rec_valid), .dma_wr(dma_wr), .dma_addr(dma_addr),
    .dma_stride(dma_stride)
  );

  ilace_run_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .stop_req(stop_req),
    .fifo_empty(fifo_empty), .scan_arm(scan_arm), .idle(idle)
  );
endmodule

// File: rtl/ilace_field_seq_chk.sv
module ilace_field_seq_chk #(
  parameter int LW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_load,
  input logic          ilace_q,
  input logic          line_match,
  input logic          sub_valid,
  input logic          stop_req,
  input logic          fifo_empty,
  input logic          rec_valid,
  input logic          lower_field,
  input logic [LW-1:0] fp_m1,
  input logic          scan_arm,
  input logic          idle,
  input logic          dma_wr
);
  // R5
  field_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_match && ilace_q && !cfg_load) |=> (lower_field != $past(lower_field)));
  // R5
  porch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_match && ilace_q && !cfg_load && !lower_field) |=> (fp_m1 == $past(fp_m1) + LW'(1)));
  // R11
  prog_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_match && !ilace_q && !cfg_load) |=> $stable(lower_field));
  // R7
  no_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_match && !sub_valid && !rec_valid) |=> !dma_wr);
  // R10
  stop_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !cfg_load) |=> !scan_arm);
  // R10
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !scan_arm && !fifo_empty && !cfg_load) |=> !idle);
  // R9
  load_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (!lower_field && scan_arm && !idle));
endmodule

bind ilace_field_seq ilace_field_seq_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .ilace_q(ilace_q),
  .line_match(line_match), .sub_valid(sub_valid), .stop_req(stop_req),
  .fifo_empty(fifo_empty), .rec_valid(rec_valid), .lower_field(lower_field),
  .fp_m1(fp_m1), .scan_arm(scan_arm), .idle(idle), .dma_wr(dma_wr)
);

// File: tb/ilace_field_seq_bench.sv
module ilace_field_seq_bench;
  localparam int CLK_P = 10;
  localparam int LW = 12;
  localparam int AW = 32;
  localparam int SW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0, cfg_ilace = 1'b0;
  logic [LW-1:0] cfg_vdisp = '0, cfg_vsstart = '0, cfg_vsend = '0, cfg_vtotal = '0;
  logic sub_valid = 1'b0;
  logic [AW-1:0] sub_addr = '0;
  logic [SW-1:0] sub_stride = '0;
  logic line_match = 1'b0, stop_req = 1'b0, fifo_empty = 1'b0;
  logic [LW-1:0] vis_m1, sync_m1, bp_m1, fp_m1;
  logic bp_en, fp_en, sync_en, scan_arm, idle, lower_field, dma_wr;
  logic [AW-1:0] dma_addr;
  logic [SW:0] dma_stride;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ilace_field_seq #(.LW(LW), .AW(AW), .SW(SW)) u_ilace_field_seq (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic load(input bit il, input int vd, input int vss, input int vse, input int vt);
    cfg_ilace = il; cfg_vdisp = LW'(vd); cfg_vsstart = LW'(vss);
    cfg_vsend = LW'(vse); cfg_vtotal = LW'(vt); cfg_load = 1'b1;
    tick();
    cfg_load = 1'b0;
  endtask

  task automatic submit(input logic [AW-1:0] a, input logic [SW-1:0] s, input bit with_match);
    sub_valid = 1'b1; sub_addr = a; sub_stride = s; line_match = with_match;
    tick();
    sub_valid = 1'b0; line_match = 1'b0;
  endtask

  task automatic pulse_match();
    line_match = 1'b1;
    tick();
    line_match = 1'b0;
  endtask

  task automatic t_reset();
    check("R12 idle", 64'(idle), 64'd1);
    check("R12 arm", 64'(scan_arm), 64'd0);
    check("R12 lower", 64'(lower_field), 64'd0);
    check("R12 wr", 64'(dma_wr), 64'd0);
    check("R12 addr", 64'(dma_addr), 64'd0);
    check("R12 stride", 64'(dma_stride), 64'd0);
  endtask

  // 525-line interlaced: field_vis 240, field_tot 262, fp0 3, bp 19
  task automatic t_ilace_geom();
    load(1'b1, 480, 488, 494, 525);
    check("R9 arm", 64'(scan_arm), 64'd1);
    check("R9 idle", 64'(idle), 64'd0);
    check("R9 lower", 64'(lower_field), 64'd0);
    check("R1 vis", 64'(vis_m1), 64'd239);
    check("R1 sync", 64'(sync_m1), 64'd260);
    check("R2 fp upper", 64'(fp_m1), 64'd2);
    check("R3 bp", 64'(bp_m1), 64'd18);
    check("R3 en", {61'd0, bp_en, fp_en, sync_en}, 64'd7);
  endtask

  // threshold: vsstart = vdisp+3 -> fp0 1; bp = 241-240-1 = 0
  task automatic t_short_porch();
    load(1'b1, 480, 483, 484, 483);
    check("R2 fp below threshold", 64'(fp_m1), 64'd0);
    check("R3 zero bp disables", 64'(bp_en), 64'd0);
    check("R3 fp/sync forced", {62'd0, fp_en, sync_en}, 64'd3);
    load(1'b1, 480, 484, 486, 525);
    check("R2 fp at threshold", 64'(fp_m1), 64'd0);
    check("R3 bp at threshold", 64'(bp_m1), 64'd20);
  endtask

  task automatic t_flip_and_address();
    load(1'b1, 480, 488, 494, 525);
    pulse_match();
    check("R7 no buffer no write", 64'(dma_wr), 64'd0);
    check("R5 toggled without buffer", 64'(lower_field), 64'd1);
    pulse_match();
    submit(32'h1000, 16'h100, 1'b0);
    check("R6 wr", 64'(dma_wr), 64'd1);
    check("R6 upper addr", 64'(dma_addr), 64'h1000);
    check("R6 doubled stride", 64'(dma_stride), 64'h200);
    tick();
    check("R6 wr one cycle", 64'(dma_wr), 64'd0);
    pulse_match();
    check("R5 lower", 64'(lower_field), 64'd1);
    check("R5 fp lower", 64'(fp_m1), 64'd3);
    check("R7 reissue wr", 64'(dma_wr), 64'd1);
    check("R7 lower addr", 64'(dma_addr), 64'h1100);
    pulse_match();
    check("R5 back to upper fp", 64'(fp_m1), 64'd2);
    check("R7 upper addr", 64'(dma_addr), 64'h1000);
    pulse_match();
    submit(32'h2000, 16'h80, 1'b0);
    check("R6 lower submit addr", 64'(dma_addr), 64'h2080);
    check("R6 lower submit stride", 64'(dma_stride), 64'h100);
  endtask

  task automatic t_same_cycle();
    // currently lower; match+submit -> upper, no offset
    submit(32'h3000, 16'h40, 1'b1);
    check("R8 flag to upper", 64'(lower_field), 64'd0);
    check("R8 upper addr", 64'(dma_addr), 64'h3000);
    submit(32'h4000, 16'h40, 1'b1);
    check("R8 flag to lower", 64'(lower_field), 64'd1);
    check("R8 lower addr", 64'(dma_addr), 64'h4040);
  endtask

  task automatic t_stop_drain();
    fifo_empty = 1'b0;
    stop_req = 1'b1;
    tick();
    stop_req = 1'b0;
    check("R10 disarmed", 64'(scan_arm), 64'd0);
    check("R10 not idle yet", 64'(idle), 64'd0);
    pulse_match();
    check("R10 record cleared", 64'(dma_wr), 64'd0);
    tick();
    check("R10 still draining", 64'(idle), 64'd0);
    fifo_empty = 1'b1;
    tick();
    check("R10 idle after drain", 64'(idle), 64'd1);
    fifo_empty = 1'b0;
  endtask

  task automatic t_progressive();
    load(1'b0, 480, 490, 492, 525);
    check("R4 vis", 64'(vis_m1), 64'd479);
    check("R4 sync", 64'(sync_m1), 64'd1);
    check("R4 bp", 64'(bp_m1), 64'd34);
    check("R4 fp", 64'(fp_m1), 64'd9);
    check("R4 en", {61'd0, bp_en, fp_en, sync_en}, 64'd7);
    submit(32'h5000, 16'h100, 1'b0);
    check("R11 addr", 64'(dma_addr), 64'h5000);
    check("R11 stride", 64'(dma_stride), 64'h100);
    pulse_match();
    check("R11 lower unchanged", 64'(lower_field), 64'd0);
    check("R11 no write", 64'(dma_wr), 64'd0);
    check("R11 fp unchanged", 64'(fp_m1), 64'd9);
    load(1'b0, 480, 480, 480, 480);
    check("R4 zero spans", {61'd0, bp_en, fp_en, sync_en}, 64'd0);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_ilace_geom();
    t_short_porch();
    t_flip_and_address();
    t_same_cycle();
    t_stop_drain();
    t_progressive();
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule